// File: doc/BRIEF.md
# Salvage Victim Assignment Engine

This engine configures the repair mapping of one cache set after power-on memory test. Test has already filled the set's fault row: one vector per way, with a bit for each data division and one more bit for the tag. The engine reads that row and decides which damaged ways give up their storage. A way that gives up its storage is called a donor. For each other damaged way, the engine decides which donor supplies the divisions that are missing. It then writes back the fault row and a row of donor indices.

The search is greedy. Donors are chosen first from ways whose tag is broken, in index order. After that, the lowest-indexed damaged way with a working tag is sacrificed, and this repeats. For each donor, the engine keeps claiming the lowest-indexed compatible damaged way until the donor has no good division left, or until no compatible way remains. Each claim takes one clock cycle. A controller above the engine pulses start once per set and waits for done.

Top module: `victim_map_cfg`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `map_rd_o` and `map_wr_o` are all low.
- R2: A start pulse sampled while idle raises `map_rd_o` for exactly one cycle, in the next cycle. The row on `map_rd_fault_i` is taken one cycle after `map_rd_o`. Way w occupies bits [w*(DIVS+1) +: DIVS+1] of each fault row, and bit DIVS of each slice is the tag fault bit. Way w occupies bits [w*IW +: IW] of the donor row.
- R3: A way whose fault vector reads as all zero is written back unchanged, and its donor entry holds its own index.
- R4: A damaged way j can be served by donor i only when the bitwise AND of their vectors is zero, where donor i's tag bit has already been forced to 1.
- R5: Ways with the tag bit set are taken as donors first, in ascending index order. Each donor claims compatible ways lowest index first.
- R6: Once no damaged way with a broken tag remains unclaimed, the lowest-indexed remaining damaged way is sacrificed: its tag bit is set and it claims ways by the rule in R5. This repeats until no damaged way remains unclaimed.
- R7: A claimed way keeps its fault vector unchanged, and its donor entry holds the donor's index.
- R8: Every donor is written back with all fault bits set and with its own index as donor entry. This includes a damaged way that finds no partner.
- R9: Exactly one write strobe `map_wr_o` follows each read. It comes 3 + 2V + B cycles after the read strobe, where V is the number of donors and B the number of claimed ways.
- R10: `done_o` is high for one cycle, in the cycle after the write strobe, and `busy_o` is low in that cycle. `busy_o` is high from the read strobe through the write strobe.
- R11: A start pulse while `busy_o` is high is ignored: it causes no additional read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, one set per pulse |
| busy_o | output | 1 | Engine is processing a set |
| done_o | output | 1 | One-cycle completion pulse |
| map_rd_o | output | 1 | Read strobe for the set's fault row |
| map_rd_fault_i | input | WAYS*(DIVS+1) | Fault row, valid one cycle after the read strobe |
| map_wr_o | output | 1 | Write strobe for the updated rows |
| map_wr_fault_o | output | WAYS*(DIVS+1) | Updated fault row |
| map_wr_victim_o | output | WAYS*IW | Donor index for every way |

## Verification
The read strobe is due one cycle after start is sampled, and the row is returned by a one-cycle memory model. The write strobe is due exactly 3 + 2V + B cycles after the read strobe, and done is due one cycle after that. The bench reference model computes V and B for every row alongside the expected rows. The monitor samples on falling edges, restarts its cycle counter at the read strobe and compares the count when the write strobe appears. On the cycle after the write strobe it checks the done pulse and the idle state.

// File: rtl/victim_map_cfg.sv
module victim_map_cfg #(
  parameter int WAYS = 4,
  parameter int DIVS = 4,
  parameter int IW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       map_rd_o,
  input  logic [WAYS*(DIVS+1)-1:0]   map_rd_fault_i,
  output logic                       map_wr_o,
  output logic [WAYS*(DIVS+1)-1:0]   map_wr_fault_o,
  output logic [WAYS*IW-1:0]         map_wr_victim_o
);
  localparam int FW = DIVS + 1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CAPT, S_PICK, S_SRCH, S_WRITE} st_t;

  st_t             state;
  logic [FW-1:0]   fv  [WAYS];
  logic [IW-1:0]   vic [WAYS];
  logic [WAYS-1:0] pool, tagf, compat;
  logic [IW-1:0]   cur, pick_idx, ben_idx;
  logic            done_q, cur_full;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tagf[w]   = pool[w] & fv[w][DIVS];
      compat[w] = pool[w] & ((fv[w] & fv[cur]) == '0);
    end
  end

  always_comb begin
    pick_idx = '0;
    ben_idx  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if ((|tagf) ? tagf[w] : pool[w]) pick_idx = IW'(w);
      if (compat[w]) ben_idx = IW'(w);
    end
  end

  assign cur_full = &fv[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done_q <= 1'b0;
      pool   <= '0;
      cur    <= '0;
      for (int w = 0; w < WAYS; w++) begin
        fv[w]  <= '0;
        vic[w] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE:  if (start_i) state <= S_READ;
        S_READ:  state <= S_CAPT;
        S_CAPT: begin
          for (int w = 0; w < WAYS; w++) begin
            fv[w]   <= map_rd_fault_i[w*FW +: FW];
            vic[w]  <= IW'(w);
            pool[w] <= |map_rd_fault_i[w*FW +: FW];
          end
          state <= S_PICK;
        end
        S_PICK: begin
          if (|pool) begin
            cur                <= pick_idx;
            fv[pick_idx][DIVS] <= 1'b1;
            pool[pick_idx]     <= 1'b0;
            state              <= S_SRCH;
          end else begin
            state <= S_WRITE;
          end
        end
        S_SRCH: begin
          if (cur_full || !(|compat)) begin
            fv[cur] <= '1;
            state   <= S_PICK;
          end else begin
            fv[cur]       <= fv[cur] | fv[ben_idx];
            vic[ben_idx]  <= cur;
            pool[ben_idx] <= 1'b0;
          end
        end
        S_WRITE: begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != S_IDLE);
  assign map_rd_o = (state == S_READ);
  assign map_wr_o = (state == S_WRITE);
  assign done_o   = done_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_pack
    assign map_wr_fault_o[w*FW +: FW]  = fv[w];
    assign map_wr_victim_o[w*IW +: IW] = vic[w];
  end
endmodule

// File: rtl/victim_map_cfg_chk.sv
module victim_map_cfg_chk #(
  parameter int WAYS = 4,
  parameter int DIVS = 4,
  parameter int IW   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     map_rd_o,
  input logic [WAYS*(DIVS+1)-1:0] map_rd_fault_i,
  input logic                     map_wr_o,
  input logic [WAYS*(DIVS+1)-1:0] map_wr_fault_o,
  input logic [WAYS*IW-1:0]       map_wr_victim_o
);
  localparam int FW = DIVS + 1;

  logic          rd_q;
  logic [FW-1:0] snap [WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      for (int w = 0; w < WAYS; w++) snap[w] <= '0;
    end else begin
      rd_q <= map_rd_o;
      if (rd_q)
        for (int w = 0; w < WAYS; w++) snap[w] <= map_rd_fault_i[w*FW +: FW];
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!map_rd_o && !map_wr_o)); // R1

  AST_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> map_rd_o); // R2

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !map_wr_o) |=> !map_rd_o); // R11

  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_o |=> (done_o && !busy_o)); // R10

  AST_DONE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(map_wr_o)); // R10

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [IW-1:0] v_w;
    logic [FW-1:0] f_w;
    assign v_w = map_wr_victim_o[w*IW +: IW];
    assign f_w = map_wr_fault_o[w*FW +: FW];

    AST_PERFECT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_o && snap[w] == '0) |-> (v_w == IW'(w) && f_w == '0)); // R3

    AST_CLAIMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_o && v_w != IW'(w)) |-> (f_w == snap[w])); // R7

    AST_CLAIMED_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_o && v_w != IW'(w)) |->
        (!snap[w][DIVS] && ((snap[v_w][DIVS-1:0] & snap[w][DIVS-1:0]) == '0))); // R4

    AST_DONOR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_o && v_w == IW'(w) && snap[w] != '0) |-> (&f_w)); // R8
  end
endmodule

bind victim_map_cfg victim_map_cfg_chk #(.WAYS(WAYS), .DIVS(DIVS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .map_rd_o(map_rd_o), .map_rd_fault_i(map_rd_fault_i), .map_wr_o(map_wr_o),
  .map_wr_fault_o(map_wr_fault_o), .map_wr_victim_o(map_wr_victim_o)
);

// File: tb/test_victim_map_cfg.sv
module test_victim_map_cfg;
  localparam int WAYS = 4;
  localparam int DIVS = 4;
  localparam int IW   = 2;
  localparam int FW   = DIVS + 1;
  localparam int RW   = WAYS * FW;
  localparam int VW   = WAYS * IW;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, map_rd_o, map_wr_o;
  logic [RW-1:0] map_rd_fault_i = '0, row_mem = '0, map_wr_fault_o;
  logic [VW-1:0] map_wr_victim_o;

  int vectors = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
  bit finished = 1'b0;
  logic [RW-1:0] q_fault [$];
  logic [VW-1:0] q_vic [$];
  int            q_lat [$];

  always #4 clk = ~clk;

  always @(posedge clk) if (map_rd_o) map_rd_fault_i <= row_mem;

  victim_map_cfg #(.WAYS(WAYS), .DIVS(DIVS), .IW(IW)) i_victim_map_cfg (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .map_rd_o(map_rd_o), .map_rd_fault_i(map_rd_fault_i), .map_wr_o(map_wr_o),
    .map_wr_fault_o(map_wr_fault_o), .map_wr_victim_o(map_wr_victim_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [RW-1:0] row, output logic [RW-1:0] fo,
                                output logic [VW-1:0] vo, output int lat);
    logic [FW-1:0] f [WAYS];
    bit p [WAYS];
    int nv = 0, nb = 0;
    for (int w = 0; w < WAYS; w++) begin
      f[w] = row[w*FW +: FW];
      p[w] = (f[w] != '0);
      vo[w*IW +: IW] = IW'(w);
    end
    while (1) begin
      int c = -1;
      for (int w = 0; w < WAYS; w++) if (c < 0 && p[w] && f[w][DIVS]) c = w;
      for (int w = 0; w < WAYS; w++) if (c < 0 && p[w]) c = w;
      if (c < 0) break;
      nv++;
      p[c] = 1'b0;
      f[c][DIVS] = 1'b1;
      while (f[c] != '1) begin
        int b = -1;
        for (int j = 0; j < WAYS; j++) if (b < 0 && p[j] && ((f[j] & f[c]) == '0)) b = j;
        if (b < 0) break;
        f[c] = f[c] | f[b];
        p[b] = 1'b0;
        vo[b*IW +: IW] = IW'(c);
        nb++;
      end
      f[c] = '1;
    end
    for (int w = 0; w < WAYS; w++) fo[w*FW +: FW] = f[w];
    lat = 3 + 2 * nv + nb;
  endfunction

  task automatic run(input logic [RW-1:0] row, input bit extra_start);
    logic [RW-1:0] fo;
    logic [VW-1:0] vo;
    int lat;
    model(row, fo, vo, lat);
    q_fault.push_back(fo);
    q_vic.push_back(vo);
    q_lat.push_back(lat);
    row_mem = row;
    rd_cnt = 0;
    wr_cnt = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (extra_start) begin
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(rd_cnt == 1, "R2 R11", "reads per run", 64'(rd_cnt), 64'd1);
    chk(wr_cnt == 1, "R9 R11", "writes per run", 64'(wr_cnt), 64'd1);
  endtask

  initial begin : monitor
    int cyc = 0;
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) begin
        chk(done_o && !busy_o, "R10", "done pulse after write", {62'd0, done_o, busy_o}, 64'h2);
        pend = 1'b0;
      end else if (rst_n && done_o) begin
        chk(1'b0, "R10", "done without write", 64'd1, 64'd0);
      end
      if (map_rd_o) begin
        rd_cnt++;
        cyc = 0;
      end else begin
        cyc++;
      end
      if (map_rd_o || map_wr_o)
        chk(busy_o, "R10", "busy during run", 64'(busy_o), 64'd1);
      if (map_wr_o) begin
        wr_cnt++;
        pend = 1'b1;
        if (q_lat.size() == 0) begin
          chk(1'b0, "R9", "unexpected write", 64'd1, 64'd0);
        end else begin
          logic [RW-1:0] ef;
          logic [VW-1:0] ev;
          int el;
          ef = q_fault.pop_front();
          ev = q_vic.pop_front();
          el = q_lat.pop_front();
          chk(map_wr_fault_o == ef, "R3 R4 R5 R6 R7 R8", "fault row", 64'(map_wr_fault_o), 64'(ef));
          chk(map_wr_victim_o == ev, "R3 R5 R6 R7 R8", "donor row", 64'(map_wr_victim_o), 64'(ev));
          chk(cyc == el, "R9", "write latency", 64'(cyc), 64'(el));
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 64'd1, 64'd0);
    summary();
  end

  initial begin : driver
    logic [RW-1:0] r;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !map_rd_o && !map_wr_o, "R1", "outputs in reset",
        {60'd0, busy_o, done_o, map_rd_o, map_wr_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !map_rd_o && !map_wr_o, "R1", "idle after reset",
        {60'd0, busy_o, done_o, map_rd_o, map_wr_o}, 64'd0);

    // R5: example row, way 0 donor for ways 1, 2 and 3
    r = {5'b00010, 5'b01000, 5'b00001, 5'b10100};
    run(r, 1'b0);
    chk(map_wr_fault_o == {5'b00010, 5'b01000, 5'b00001, 5'b11111}, "R5 R8", "example fault row",
        64'(map_wr_fault_o), 64'(RW'({5'b00010, 5'b01000, 5'b00001, 5'b11111})));
    chk(map_wr_victim_o == '0, "R5 R7", "example donor row", 64'(map_wr_victim_o), 64'd0);

    run('0, 1'b0);                                   // R3 clean set
    run({5'b00000, 5'b00000, 5'b00100, 5'b00000}, 1'b0); // R8 lone damaged way
    run({5'b00000, 5'b00010, 5'b00001, 5'b00000}, 1'b0); // R6 way1 sacrificed for way2
    run({5'b00000, 5'b00001, 5'b00001, 5'b00000}, 1'b0); // R6 incompatible pair
    run({5'b10000, 5'b00001, 5'b10010, 5'b00001}, 1'b0); // R5 two broken tags
    run('1, 1'b0);                                   // R8 everything broken
    run({5'b00000, 5'b01000, 5'b00010, 5'b10001}, 1'b1); // R11 start while busy

    for (int n = 0; n < 400; n++) begin
      for (int b = 0; b < RW; b++) r[b] = (($urandom % 4) == 0);
      run(r, (n % 7) == 0);
    end
    chk(q_lat.size() == 0, "R9", "pending results", 64'(q_lat.size()), 64'd0);
    summary();
  end
endmodule